// File: doc/BRIEF.md
# Lane-Masked Load Return Formatter

This block places returned integer load data into a vector register file. The data is a packed buffer that covers every lane of a wavefront and up to four destination registers. A request gives the element type, the destination width, the register count, the destination registers and an execution mask. On a start pulse the block copies the whole request. It then visits one lane per cycle, in ascending lane order within each register and register by register. For every lane whose mask bit is set, it emits one register-file write strobe carrying the widened element.

Each element is sign- or zero-extended to the destination width. The destination register comes from one of two sources: for short requests it is the base register plus the operand index, and for longer ones it is taken from an explicit per-operand list. Requests that exceed the maximum memory-instruction width, or that pair a 64-bit element with a 32-bit destination, are refused. A refused request raises an error alongside completion and makes no write.

Top module: `load_return_formatter`

## Requirements
- R1: After reset, busy, wr_en, done and err are all low.
- R2: A legal request accepted at a clock edge makes busy high from the next cycle. Step n = k*WAVE_LANES + i (register index k, lane i) is presented in the (n+1)-th cycle after the accepting edge, one step per cycle.
- R3: The buffer is packed at element size, least significant byte first. The element for register index k and lane i starts at byte (k*WAVE_LANES + i) * element_bytes.
- R4: elem_kind[1:0] selects 8, 16, 32 or 64 bits (codes 0 to 3). When elem_kind[2] is 0, the element is zero-extended.
- R5: When elem_kind[2] is 1, the element is sign-extended to the destination width.
- R6: With dst_wide at 0 the destination is 32 bits and wr_data[63:32] is zero. With dst_wide at 1 all 64 bits are used.
- R7: A lane whose exec_mask bit is 0 still takes its cycle, but wr_en stays low in that cycle.
- R8: When reg_cnt is 1 or 2, register index k writes register base_reg + k, modulo 256.
- R9: When reg_cnt is 3 or 4, register index k writes the register given in reg_list[8k+7:8k].
- R10: done is high for exactly one cycle, the cycle after the last step. err is low in that cycle.
- R11: A request is illegal when reg_cnt is 0 or above 4, when a 64-bit element meets a 32-bit destination, or when element_bytes * reg_cnt exceeds 16. An illegal request makes no write, and raises done and err together in the cycle after the accepting edge.
- R12: A start pulse while busy is ignored. The request in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, taken only when idle |
| elem_kind | input | 3 | Bit 2: signed; bits 1:0: element size code |
| dst_wide | input | 1 | 1 = 64-bit destination, 0 = 32-bit |
| reg_cnt | input | 3 | Number of destination registers |
| base_reg | input | 8 | First destination register for short requests |
| reg_list | input | 32 | Per-operand register list, 8 bits per entry |
| exec_mask | input | 16 | One enable bit per lane |
| data_buf | input | 2048 | Packed returned data |
| busy | output | 1 | Request in progress |
| wr_en | output | 1 | Register-file write strobe |
| wr_reg | output | 8 | Register written |
| wr_lane | output | 4 | Lane written |
| wr_data | output | 64 | Widened element |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request refused, high together with done |

## Verification
Every write is due at a cycle fixed by its step number: step n appears in the (n+1)-th cycle after the edge that took the start pulse. The done pulse follows one cycle after the final step. For a refused request, done and err appear in the first cycle after the accepting edge. The driver stores the absolute cycle number with every expected write and completion. The monitor samples at the falling edge and flags any write or completion that comes early, late, or without an expected entry, as well as any expected item that does not appear in its cycle.

// File: rtl/lrf_pkg.sv
// Shared types and helper functions for the load return formatter.
// Assumes element sizes are powers of two from 1 to 8 bytes.
package lrf_pkg;

    typedef enum logic [1:0] {
        SZ_B8  = 2'd0,
        SZ_B16 = 2'd1,
        SZ_B32 = 2'd2,
        SZ_B64 = 2'd3
    } elem_size_e;

    typedef struct packed {
        logic       is_signed;
        elem_size_e size;
    } elem_kind_t;

    // Decide whether a request fits the register and width limits.
    function automatic logic req_legal(elem_kind_t kind, logic wide, int cnt,
                                       int max_regs, int max_bytes);
        int nbytes;
        nbytes = (1 << kind.size) * cnt;
        return (cnt != 0) && (cnt <= max_regs) &&
               !((kind.size == SZ_B64) && !wide) && (nbytes <= max_bytes);
    endfunction

    // Extend a raw element to the destination width; upper half cleared for 32-bit.
    function automatic logic [63:0] widen(logic [63:0] raw, elem_kind_t kind, logic wide);
        logic [63:0] r;
        case (kind.size)
            SZ_B8:   r = kind.is_signed ? {{56{raw[7]}},  raw[7:0]}  : {56'd0, raw[7:0]};
            SZ_B16:  r = kind.is_signed ? {{48{raw[15]}}, raw[15:0]} : {48'd0, raw[15:0]};
            SZ_B32:  r = kind.is_signed ? {{32{raw[31]}}, raw[31:0]} : {32'd0, raw[31:0]};
            default: r = raw;
        endcase
        if (!wide) r[63:32] = 32'd0;
        return r;
    endfunction

endpackage

// File: rtl/lrf_seq.sv
// Lane and register sequencer. Accepts a request when idle, then steps
// one lane per cycle through every lane of each destination register.
// Assumes WF and MAX_REGS are powers of two of at least 2, and nreg
// holds the captured register count from the accepting edge onward.
module lrf_seq #(
    parameter int WF       = 16,
    parameter int MAX_REGS = 4,
    parameter int CNT_W    = 3,
    parameter int LANE_W   = $clog2(WF),
    parameter int RIDX_W   = $clog2(MAX_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              legal,
    input  logic [CNT_W-1:0]  nreg,
    output logic              accept,
    output logic              busy,
    output logic [LANE_W-1:0] lane,
    output logic [RIDX_W-1:0] ridx,
    output logic              done,
    output logic              err
);

    logic              busy_q, done_q, err_q;
    logic [LANE_W-1:0] lane_q;
    logic [RIDX_W-1:0] ridx_q;
    logic              last_lane, last_reg;

    // Work out acceptance and end-of-walk conditions.
    always_comb begin
        accept    = start && !busy_q;
        last_lane = (lane_q == LANE_W'(WF - 1));
        last_reg  = ((int'(ridx_q) + 1) == int'(nreg));
    end

    // Advance the lane/register walk and produce the completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            lane_q <= '0;
            ridx_q <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (accept) begin
                lane_q <= '0;
                ridx_q <= '0;
                if (legal) begin
                    busy_q <= 1'b1;
                end else begin
                    done_q <= 1'b1;
                    err_q  <= 1'b1;
                end
            end else if (busy_q) begin
                if (last_lane) begin
                    lane_q <= '0;
                    if (last_reg) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        ridx_q <= ridx_q + 1'b1;
                    end
                end else begin
                    lane_q <= lane_q + 1'b1;
                end
            end
        end
    end

    assign busy = busy_q;
    assign lane = lane_q;
    assign ridx = ridx_q;
    assign done = done_q;
    assign err  = err_q;

    // R2: a walk always begins at lane 0 of register index 0
    a_r2_walk_starts_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> (lane_q == '0) && (ridx_q == '0));

    // R10: the end of a walk is marked by a clean completion pulse
    a_r10_done_at_walk_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> done_q && !err_q);

    // R11: an error is reported only as a completion with no walk running
    a_r11_err_without_walk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> done_q && !busy_q);

endmodule

// File: rtl/lrf_regsel.sv
// Destination register selection. Short requests use base plus operand
// index; requests above LIST_THRESH registers read an explicit list.
// Assumes the list holds MAX_REGS entries of REG_AW bits, entry k at k*REG_AW.
module lrf_regsel #(
    parameter int MAX_REGS    = 4,
    parameter int REG_AW      = 8,
    parameter int CNT_W       = 3,
    parameter int LIST_THRESH = 2,
    parameter int RIDX_W      = $clog2(MAX_REGS)
) (
    input  logic [REG_AW-1:0]          base_i,
    input  logic [MAX_REGS*REG_AW-1:0] list_i,
    input  logic [CNT_W-1:0]           cnt_i,
    input  logic [RIDX_W-1:0]          ridx_i,
    output logic [REG_AW-1:0]          reg_o
);

    if (LIST_THRESH >= MAX_REGS) begin : g_base_only
        // The list can never be needed: always offset from the base.
        always_comb reg_o = base_i + REG_AW'(ridx_i);
    end else begin : g_with_list
        // Pick the list entry for long requests, else base plus index.
        always_comb begin
            if (int'(cnt_i) > LIST_THRESH)
                reg_o = list_i[ridx_i*REG_AW +: REG_AW];
            else
                reg_o = base_i + REG_AW'(ridx_i);
        end
    end

endmodule

// File: rtl/lrf_extract.sv
// Element extraction and widening. Selects the element at index idx_i
// from a buffer packed at element size, low byte first, then extends it.
// Assumes BUF_W is at least 64 and the index stays inside the buffer.
module lrf_extract
    import lrf_pkg::*;
#(
    parameter int BUF_W = 2048,
    parameter int IDX_W = 6
) (
    input  logic [BUF_W-1:0] buf_i,
    input  logic [IDX_W-1:0] idx_i,
    input  elem_kind_t       kind_i,
    input  logic             wide_i,
    output logic [63:0]      data_o
);

    logic [IDX_W+2:0] byte_off;
    logic [BUF_W-1:0] shifted;

    // Locate the element by byte offset and widen it.
    always_comb begin
        byte_off = {3'b000, idx_i} << kind_i.size;
        shifted  = buf_i >> {byte_off, 3'b000};
        data_o   = widen(shifted[63:0], kind_i, wide_i);
    end

endmodule

// File: rtl/load_return_formatter.sv
// Load return formatter top. Captures a request on an idle start pulse,
// then emits one register-file write per enabled lane, one lane per cycle.
// Assumes the register file accepts a write in every cycle.
module load_return_formatter
    import lrf_pkg::*;
#(
    parameter int WF             = 16,
    parameter int MAX_REGS       = 4,
    parameter int REG_AW         = 8,
    parameter int MAX_INST_BYTES = 16,
    parameter int LIST_THRESH    = 2,
    parameter int CNT_W          = 3,
    parameter int BUF_W          = WF * MAX_INST_BYTES * 8,
    parameter int LANE_W         = $clog2(WF)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [2:0]                 elem_kind,
    input  logic                       dst_wide,
    input  logic [CNT_W-1:0]           reg_cnt,
    input  logic [REG_AW-1:0]          base_reg,
    input  logic [MAX_REGS*REG_AW-1:0] reg_list,
    input  logic [WF-1:0]              exec_mask,
    input  logic [BUF_W-1:0]           data_buf,
    output logic                       busy,
    output logic                       wr_en,
    output logic [REG_AW-1:0]          wr_reg,
    output logic [LANE_W-1:0]          wr_lane,
    output logic [63:0]                wr_data,
    output logic                       done,
    output logic                       err
);

    localparam int RIDX_W = $clog2(MAX_REGS);
    localparam int IDX_W  = $clog2(MAX_REGS * WF);

    elem_kind_t                 kind_q;
    logic                       wide_q;
    logic [CNT_W-1:0]           cnt_q;
    logic [REG_AW-1:0]          base_q;
    logic [MAX_REGS*REG_AW-1:0] list_q;
    logic [WF-1:0]              mask_q;
    logic [BUF_W-1:0]           buf_q;

    logic              accept, legal, busy_w;
    logic [LANE_W-1:0] lane_w;
    logic [RIDX_W-1:0] ridx_w;
    logic [IDX_W-1:0]  elem_idx;

    // Judge the incoming request against the width and count limits.
    always_comb legal = req_legal(elem_kind_t'(elem_kind), dst_wide, int'(reg_cnt),
                                  MAX_REGS, MAX_INST_BYTES);

    // Hold the request fields for the whole walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= '0;
            wide_q <= 1'b0;
            cnt_q  <= '0;
            base_q <= '0;
            list_q <= '0;
            mask_q <= '0;
            buf_q  <= '0;
        end else if (accept) begin
            kind_q <= elem_kind_t'(elem_kind);
            wide_q <= dst_wide;
            cnt_q  <= reg_cnt;
            base_q <= base_reg;
            list_q <= reg_list;
            mask_q <= exec_mask;
            buf_q  <= data_buf;
        end
    end

    lrf_seq #(
        .WF(WF), .MAX_REGS(MAX_REGS), .CNT_W(CNT_W), .LANE_W(LANE_W), .RIDX_W(RIDX_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .legal(legal), .nreg(cnt_q),
        .accept(accept), .busy(busy_w), .lane(lane_w), .ridx(ridx_w),
        .done(done), .err(err)
    );

    lrf_regsel #(
        .MAX_REGS(MAX_REGS), .REG_AW(REG_AW), .CNT_W(CNT_W),
        .LIST_THRESH(LIST_THRESH), .RIDX_W(RIDX_W)
    ) u_regsel (
        .base_i(base_q), .list_i(list_q), .cnt_i(cnt_q), .ridx_i(ridx_w), .reg_o(wr_reg)
    );

    // Flatten register index and lane into a buffer element index.
    always_comb elem_idx = IDX_W'(int'(ridx_w) * WF + int'(lane_w));

    lrf_extract #(.BUF_W(BUF_W), .IDX_W(IDX_W)) u_extract (
        .buf_i(buf_q), .idx_i(elem_idx), .kind_i(kind_q), .wide_i(wide_q), .data_o(wr_data)
    );

    // Strobe a write only for enabled lanes of an active walk.
    always_comb begin
        busy    = busy_w;
        wr_lane = lane_w;
        wr_en   = busy_w && mask_q[lane_w];
    end

    // R12: a start pulse during a walk leaves the captured request untouched
    a_r12_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_w && start |=> $stable(kind_q) && $stable(mask_q) && $stable(cnt_q) && $stable(buf_q));

    // R6: a 32-bit destination never carries data in the upper half
    a_r6_upper_half_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wide_q |-> (wr_data[63:32] == 32'd0));

    // R5: signed bytes are replicated through the low word
    a_r5_byte_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && kind_q.is_signed && (kind_q.size == SZ_B8) |-> (wr_data[31:8] == {24{wr_data[7]}}));

    // R4: unsigned halfwords arrive with clear upper bits
    a_r4_half_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !kind_q.is_signed && (kind_q.size == SZ_B16) |-> (wr_data[63:16] == 48'd0));

endmodule

// File: tb/load_return_formatter_tb.sv
module load_return_formatter_tb;

    localparam int WF    = 16;
    localparam int BUF_B = WF * 16;
    localparam int BUF_W = BUF_B * 8;

    typedef struct {
        int          cyc;
        logic [7:0]  r;
        logic [3:0]  lane;
        logic [63:0] d;
        string       tag;
    } wr_item_t;

    typedef struct {
        int    cyc;
        bit    e;
        string tag;
    } done_item_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [2:0]       elem_kind = '0;
    logic             dst_wide = 1'b0;
    logic [2:0]       reg_cnt = '0;
    logic [7:0]       base_reg = '0;
    logic [31:0]      reg_list = '0;
    logic [15:0]      exec_mask = '0;
    logic [BUF_W-1:0] data_buf = '0;
    logic             busy, wr_en, done, err;
    logic [7:0]       wr_reg;
    logic [3:0]       wr_lane;
    logic [63:0]      wr_data;

    int cyc = 0;
    int n_checks = 0;
    int n_fails = 0;
    bit mon_on = 1'b0;
    bit finished = 1'b0;
    wr_item_t   wq[$];
    done_item_t dq[$];

    load_return_formatter u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .elem_kind(elem_kind),
        .dst_wide(dst_wide), .reg_cnt(reg_cnt), .base_reg(base_reg),
        .reg_list(reg_list), .exec_mask(exec_mask), .data_buf(data_buf),
        .busy(busy), .wr_en(wr_en), .wr_reg(wr_reg), .wr_lane(wr_lane),
        .wr_data(wr_data), .done(done), .err(err)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] pat_byte(int seed, int idx);
        return 8'((seed * 73 + idx * 29 + (idx >> 3) * 151) ^ (idx * 7 + seed));
    endfunction

    // Driver: build the buffer, push expectations, pulse start.
    task automatic launch(input bit sgn, input int sz, input bit wide, input int cnt,
                          input logic [7:0] base, input logic [31:0] list,
                          input logic [15:0] mask, input int seed, input string tag);
        logic [BUF_W-1:0] b;
        int nb, c, j;
        bit ok;
        logic [63:0] raw;
        wr_item_t it;
        done_item_t di;
        for (int x = 0; x < BUF_B; x++) b[x*8 +: 8] = pat_byte(seed, x);
        nb = 1 << sz;
        ok = (cnt >= 1) && (cnt <= 4) && !(sz == 3 && !wide) && (nb * cnt <= 16);
        c = cyc;
        if (ok) begin
            for (int k = 0; k < cnt; k++) begin
                for (int i = 0; i < WF; i++) begin
                    if (mask[i]) begin
                        j = k * WF + i;
                        raw = '0;
                        for (int y = 0; y < nb; y++) raw[y*8 +: 8] = b[(j*nb + y)*8 +: 8];
                        if (sgn && raw[nb*8-1])
                            for (int y = nb * 8; y < 64; y++) raw[y] = 1'b1;
                        if (!wide) raw[63:32] = '0;
                        it.cyc  = c + 1 + j;
                        it.r    = (cnt > 2) ? list[k*8 +: 8] : 8'(base + 8'(k));
                        it.lane = 4'(i);
                        it.d    = raw;
                        it.tag  = tag;
                        wq.push_back(it);
                    end
                end
            end
            di.cyc = c + 1 + cnt * WF;
            di.e   = 1'b0;
        end else begin
            di.cyc = c + 1;
            di.e   = 1'b1;
        end
        di.tag = tag;
        dq.push_back(di);
        elem_kind = {sgn, 2'(sz)};
        dst_wide  = wide;
        reg_cnt   = 3'(cnt);
        base_reg  = base;
        reg_list  = list;
        exec_mask = mask;
        data_buf  = b;
        start     = 1'b1;
        @(negedge clk);
        start     = 1'b0;
    endtask

    task automatic drain();
        while (wq.size() != 0 || dq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: compare writes and completions against the scoreboard.
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            if (wr_en) begin
                n_checks++;
                if (wq.size() == 0) begin
                    n_fails++;
                    $display("FAIL R7: unexpected write reg=%0d lane=%0d data=%h at cyc %0d, expected none",
                             wr_reg, wr_lane, wr_data, cyc);
                end else begin
                    wr_item_t h;
                    h = wq.pop_front();
                    if (h.cyc != cyc || h.r != wr_reg || h.lane != wr_lane || h.d != wr_data) begin
                        n_fails++;
                        $display("FAIL %s: got reg=%0d lane=%0d data=%h cyc=%0d, expected reg=%0d lane=%0d data=%h cyc=%0d",
                                 h.tag, wr_reg, wr_lane, wr_data, cyc, h.r, h.lane, h.d, h.cyc);
                    end
                end
            end else if (wq.size() != 0 && wq[0].cyc <= cyc) begin
                wr_item_t h;
                h = wq.pop_front();
                n_checks++;
                n_fails++;
                $display("FAIL %s R2: missing write at cyc %0d, expected reg=%0d lane=%0d data=%h",
                         h.tag, cyc, h.r, h.lane, h.d);
            end
            if (done) begin
                n_checks++;
                if (dq.size() == 0) begin
                    n_fails++;
                    $display("FAIL R10: unexpected done err=%0b at cyc %0d, expected none", err, cyc);
                end else begin
                    done_item_t h;
                    h = dq.pop_front();
                    if (h.cyc != cyc || h.e != err) begin
                        n_fails++;
                        $display("FAIL %s R10 R11: done at cyc=%0d err=%0b, expected cyc=%0d err=%0b",
                                 h.tag, cyc, err, h.cyc, h.e);
                    end
                end
            end else if (dq.size() != 0 && dq[0].cyc <= cyc) begin
                done_item_t h;
                h = dq.pop_front();
                n_checks++;
                n_fails++;
                $display("FAIL %s R10: done missing at cyc %0d, expected cyc=%0d err=%0b",
                         h.tag, cyc, h.cyc, h.e);
            end
        end
    end

    task automatic check_bit(input logic got, input logic exp, input string what);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL R1: %s got %0b expected %0b", what, got, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit(busy,  1'b0, "busy after reset");
        check_bit(wr_en, 1'b0, "wr_en after reset");
        check_bit(done,  1'b0, "done after reset");
        check_bit(err,   1'b0, "err after reset");
        mon_on = 1'b1;

        launch(0, 0, 0, 1, 8'd10,  32'h0,         16'hFFFF, 1, "R2 R3 R4 R6");
        drain();
        launch(1, 0, 0, 2, 8'hFF,  32'h0,         16'h5A5A, 2, "R5 R7 R8");
        drain();
        launch(1, 1, 1, 3, 8'd0,   32'h005A2928,  16'hC3E1, 3, "R3 R5 R9");
        drain();
        launch(0, 2, 1, 4, 8'd0,   32'h77665544,  16'h8001, 4, "R4 R9 R10");
        drain();
        launch(1, 2, 0, 4, 8'd0,   32'h0B0A0908,  16'hFFFF, 5, "R5 R6 R9");
        drain();
        launch(1, 3, 1, 2, 8'd3,   32'h0,         16'hF0F0, 6, "R3 R5 R8");
        drain();
        launch(0, 3, 1, 2, 8'd20,  32'h0,         16'h0FF0, 7, "R3 R4 R8");
        drain();
        launch(0, 1, 0, 1, 8'd30,  32'h0,         16'h0000, 8, "R7 R10");
        drain();
        launch(0, 3, 0, 1, 8'd1,   32'h0,         16'hFFFF, 9, "R11 wide-mismatch");
        drain();
        launch(1, 3, 1, 3, 8'd1,   32'h01020304,  16'hFFFF, 10, "R11 over-width");
        drain();
        launch(0, 0, 0, 0, 8'd1,   32'h0,         16'hFFFF, 11, "R11 zero-count");
        drain();
        launch(0, 0, 0, 5, 8'd1,   32'h0,         16'hFFFF, 12, "R11 big-count");
        drain();

        // R12: a second start during the walk must change nothing
        launch(0, 1, 1, 2, 8'd50,  32'h0,         16'hA5A5, 13, "R12");
        repeat (5) @(negedge clk);
        elem_kind = 3'b111; dst_wide = 1'b0; reg_cnt = 3'd1; base_reg = 8'd200;
        exec_mask = 16'hFFFF; data_buf = '1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        drain();
        repeat (10) @(negedge clk);

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule